// File: doc/BRIEF.md
# DMA Channel Register Bank with Interrupt Aggregation

This block is the register front end of a seven-channel DMA controller. Each channel has three 32-bit registers: a memory address, a block count and a control word. Two further global registers hold the per-channel priority and enable nibbles and the interrupt control state. Software writes these registers over a simple single-cycle register port. The block decides when a channel start pulse goes to the transfer engine. The engine is outside this block and reports back through a per-channel done pulse.

The interrupt control register mixes three kinds of bits: plain read/write bits, write-one-to-clear completion flags, and a sticky "request sent" bit. The block combines the flags, the flag enables, a global enable and a bus-error bit into one master condition. It raises a single-cycle request, meant for bit 3 of the system interrupt status, only when that condition newly becomes true. Channel 5 has no engine behind it, so writes to its registers have no effect.

Top module: `dma_regfile`

## Requirements
- R1: After reset every register reads zero, except the priority/enable register (offset 0x0F0), which reads 0x07654321. `start_o` and `irq_o` are low.
- R2: Channel n has its address, count and control registers at byte offsets 0x080+16n, 0x084+16n and 0x088+16n. The priority/enable register is at 0x0F0 and the interrupt control register at 0x0F4. A written value reads back unchanged, through the combinational `rdata_o`, from the cycle after the write.
- R3: A write to the control register of channel n with bit 24 set drives `start_o[n]` high for exactly the next cycle, but only if bit 4n+3 of the priority/enable register is set when the write happens. Otherwise no start is issued.
- R4: Writes to any channel 5 register are ignored: those registers read zero and `start_o[5]` stays low.
- R5: In the interrupt control register, the bits in mask 0x00FF803F are stored straight from the written value. Bits 6 to 14 always read zero, and bit 31 cannot be set by a write.
- R6: Flag bits 24+n (n = 0..6) are write-one-to-clear: a written 1 clears the flag and a written 0 leaves it unchanged.
- R7: A `done_i[n]` pulse sets flag bit 24+n when flag enable bit 16+n is set at that time. If the enable bit is clear, the flag does not change.
- R8: A `done_i[n]` pulse clears bit 24 of channel n's control register.
- R9: The master condition is (bit 23 AND any of bits 24..30) OR bit 15, evaluated on the register's next value. When it is true and bit 31 (sent) is clear, `irq_o` is high for one cycle in the cycle after the causing event, and bit 31 becomes set.
- R10: While bit 31 is set, `irq_o` is not raised again. Bit 31 clears as soon as the master condition becomes false, after which a new master condition raises `irq_o` again.
- R11: In the same cycle, a done-driven flag set overrides a write-one-to-clear of that flag, and a control-register write overrides the done-driven clear of bit 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 8 | Byte offset for both write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| done_i | input | 7 | Per-channel completion pulse from the transfer engine |
| start_o | output | 7 | Per-channel start pulse to the transfer engine |
| irq_o | output | 1 | One-cycle request to set bit 3 of the system interrupt status |

## Verification
Two functions can act in the same cycle: a completion from the engine, and a software write that targets the same state. A write to the interrupt control register that clears a flag while `done_i` sets that same flag must leave the flag set. A control-register write that lands together with a done pulse must keep the written value and still issue a start. The bench drives both coincidences from single vectors, with `we_i` and `done_i` asserted together. It judges the result by reading the registers back and by watching `start_o` and `irq_o` in the following cycle.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int CH_BASE     = 'h80;
  localparam int CH_STRIDE   = 16;
  localparam int OFS_MADR    = 0;
  localparam int OFS_BCR     = 4;
  localparam int OFS_CTRL    = 8;
  localparam int PCR_OFS     = 'hF0;
  localparam int ICR_OFS     = 'hF4;
  localparam int GO_BIT      = 24;
  localparam logic [31:0] ICR_RW_MASK = 32'h00FF803F;
  localparam int ICR_BERR    = 15;
  localparam int ICR_EN_LSB  = 16;
  localparam int ICR_GLB     = 23;
  localparam int ICR_FLG_LSB = 24;
  localparam int ICR_SENT    = 31;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int DW = 32,
  parameter int GO = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_madr_i,
  input  logic          wr_bcr_i,
  input  logic          wr_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          en_i,
  input  logic          done_i,
  output logic [DW-1:0] madr_o,
  output logic [DW-1:0] bcr_o,
  output logic [DW-1:0] ctrl_o,
  output logic          start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      madr_o  <= '0;
      bcr_o   <= '0;
      ctrl_o  <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= wr_ctrl_i && wdata_i[GO] && en_i;
      if (wr_madr_i) madr_o <= wdata_i;
      if (wr_bcr_i)  bcr_o  <= wdata_i;
      // software write wins over engine completion
      if (wr_ctrl_i)   ctrl_o     <= wdata_i;
      else if (done_i) ctrl_o[GO] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_icr.sv
module dma_icr
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [31:0]       icr_o,
  output logic              irq_o
);
  logic [31:0]       rw_q, rw_d;
  logic [NUM_CH-1:0] flg_q, flg_d, flg_clr, flg_set;
  logic              sent_q, master;

  always_comb begin
    rw_d    = wr_i ? (wdata_i & ICR_RW_MASK) : rw_q;
    flg_clr = wr_i ? wdata_i[ICR_FLG_LSB +: NUM_CH] : '0;
    flg_set = done_i & rw_q[ICR_EN_LSB +: NUM_CH];
    // completion set has priority over write-one-to-clear
    flg_d   = (flg_q & ~flg_clr) | flg_set;
    master  = (rw_d[ICR_GLB] && (|flg_d)) || rw_d[ICR_BERR];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rw_q   <= '0;
      flg_q  <= '0;
      sent_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      rw_q   <= rw_d;
      flg_q  <= flg_d;
      sent_q <= master;
      irq_o  <= master && !sent_q;
    end
  end

  always_comb begin
    icr_o = rw_q;
    icr_o[ICR_FLG_LSB +: NUM_CH] = flg_q;
    icr_o[ICR_SENT] = sent_q;
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int          NUM_CH  = 7,
  parameter int          GAP_CH  = 5,
  parameter int          AW      = 8,
  parameter int          DW      = 32,
  parameter logic [31:0] PCR_RST = 32'h07654321
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] start_o,
  output logic              irq_o
);
  localparam logic [AW-1:0] A_PCR = AW'(PCR_OFS);
  localparam logic [AW-1:0] A_ICR = AW'(ICR_OFS);

  logic [DW-1:0]     madr [NUM_CH];
  logic [DW-1:0]     bcr  [NUM_CH];
  logic [DW-1:0]     ctrl [NUM_CH];
  logic [NUM_CH-1:0] wr_madr, wr_bcr, wr_ctrl, busy;
  logic [31:0]       pcr_q, icr_q;
  logic              wr_pcr, wr_icr;

  assign wr_pcr = we_i && (addr_i == A_PCR);
  assign wr_icr = we_i && (addr_i == A_ICR);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [AW-1:0] A_M = AW'(CH_BASE + CH_STRIDE*n + OFS_MADR);
    localparam logic [AW-1:0] A_B = AW'(CH_BASE + CH_STRIDE*n + OFS_BCR);
    localparam logic [AW-1:0] A_C = AW'(CH_BASE + CH_STRIDE*n + OFS_CTRL);
    localparam bit LIVE = (n != GAP_CH);

    assign wr_madr[n] = LIVE && we_i && (addr_i == A_M);
    assign wr_bcr[n]  = LIVE && we_i && (addr_i == A_B);
    assign wr_ctrl[n] = LIVE && we_i && (addr_i == A_C);
    assign busy[n]    = ctrl[n][GO_BIT];

    dma_chan_regs #(.DW(DW), .GO(GO_BIT)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_madr_i (wr_madr[n]),
      .wr_bcr_i  (wr_bcr[n]),
      .wr_ctrl_i (wr_ctrl[n]),
      .wdata_i   (wdata_i),
      .en_i      (pcr_q[4*n+3]),
      .done_i    (done_i[n]),
      .madr_o    (madr[n]),
      .bcr_o     (bcr[n]),
      .ctrl_o    (ctrl[n]),
      .start_o   (start_o[n])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcr_q <= PCR_RST;
    else if (wr_pcr) pcr_q <= wdata_i;
  end

  dma_icr #(.NUM_CH(NUM_CH)) u_icr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_icr),
    .wdata_i (wdata_i),
    .done_i  (done_i),
    .icr_o   (icr_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_PCR) rdata_o = pcr_q;
    if (addr_i == A_ICR) rdata_o = icr_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr_i == AW'(CH_BASE + CH_STRIDE*n + OFS_MADR)) rdata_o = madr[n];
      if (addr_i == AW'(CH_BASE + CH_STRIDE*n + OFS_BCR))  rdata_o = bcr[n];
      if (addr_i == AW'(CH_BASE + CH_STRIDE*n + OFS_CTRL)) rdata_o = ctrl[n];
    end
  end
endmodule

// File: rtl/dma_rf_checker.sv
module dma_rf_checker
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [NUM_CH-1:0] done_i,
  input logic [NUM_CH-1:0] start_o,
  input logic              irq_o,
  input logic [31:0]       pcr_q,
  input logic [31:0]       icr_q,
  input logic [NUM_CH-1:0] busy
);
  localparam logic [AW-1:0] A_ICR = AW'(ICR_OFS);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    localparam logic [AW-1:0] A_C = AW'(CH_BASE + CH_STRIDE*n + OFS_CTRL);

    AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[n] |-> $past(we_i && addr_i == A_C && wdata_i[GO_BIT])); // R3
    AST_START_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[n] |-> $past(pcr_q[4*n+3])); // R3
    AST_FLAG_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_ICR && wdata_i[ICR_FLG_LSB+n] && !done_i[n])
      |=> !icr_q[ICR_FLG_LSB+n]); // R6
    AST_DONE_CLEARS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i[n] && !(we_i && addr_i == A_C)) |=> !busy[n]); // R8
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R10
  AST_IRQ_MARKS_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> icr_q[ICR_SENT]); // R9
  AST_SENT_NEEDS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icr_q[ICR_SENT] |-> ((icr_q[ICR_GLB] && (|icr_q[30:24])) || icr_q[ICR_BERR])); // R10
endmodule

bind dma_regfile dma_rf_checker #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .done_i  (done_i),
  .start_o (start_o),
  .irq_o   (irq_o),
  .pcr_q   (pcr_q),
  .icr_q   (icr_q),
  .busy    (busy)
);

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;
  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [6:0]  done;
    logic [6:0]  st;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'hF0, 32'h07654321, 7'h00, 7'h00, 1'b0, 4'd1},  // R1
    '{1'b1, 1'b0, 8'hF4, 32'h00000000, 7'h00, 7'h00, 1'b0, 4'd1},  // R1
    '{1'b1, 1'b0, 8'hA8, 32'h00000000, 7'h00, 7'h00, 1'b0, 4'd1},  // R1
    '{1'b0, 1'b1, 8'hA8, 32'h01000201, 7'h00, 7'h00, 1'b0, 4'd3},  // R3 enable clear
    '{1'b1, 1'b0, 8'hA8, 32'h01000201, 7'h00, 7'h00, 1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 8'hF0, 32'h0FE54B29, 7'h00, 7'h00, 1'b0, 4'd3},  // R3 enables ch0,2,5,6
    '{1'b1, 1'b0, 8'hF0, 32'h0FE54B29, 7'h00, 7'h00, 1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 8'hA8, 32'h01000000, 7'h00, 7'h04, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 8'h88, 32'h00000001, 7'h00, 7'h00, 1'b0, 4'd3},  // R3 go bit clear
    '{1'b0, 1'b1, 8'h88, 32'h01000000, 7'h00, 7'h01, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 8'hE8, 32'h01000000, 7'h00, 7'h40, 1'b0, 4'd3},  // R3
    '{1'b0, 1'b1, 8'hD8, 32'h01000000, 7'h00, 7'h00, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b0, 8'hD8, 32'h00000000, 7'h00, 7'h00, 1'b0, 4'd4},  // R4
    '{1'b0, 1'b1, 8'hD0, 32'h00001234, 7'h00, 7'h00, 1'b0, 4'd4},  // R4
    '{1'b1, 1'b0, 8'hD0, 32'h00000000, 7'h00, 7'h00, 1'b0, 4'd4},  // R4
    '{1'b0, 1'b1, 8'hE0, 32'h00ABCDEF, 7'h00, 7'h00, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 8'hE0, 32'h00ABCDEF, 7'h00, 7'h00, 1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 8'hE4, 32'h00100010, 7'h00, 7'h00, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b0, 8'hE4, 32'h00100010, 7'h00, 7'h00, 1'b0, 4'd2},  // R2
    '{1'b0, 1'b1, 8'hF4, 32'hFFFFFFFF, 7'h00, 7'h00, 1'b1, 4'd9},  // R9 bus error
    '{1'b1, 1'b0, 8'hF4, 32'h80FF803F, 7'h00, 7'h00, 1'b0, 4'd5},  // R5
    '{1'b0, 1'b1, 8'hF4, 32'hFFFFFFFF, 7'h00, 7'h00, 1'b0, 4'd10}, // R10 no re-raise
    '{1'b0, 1'b1, 8'hF4, 32'h00000000, 7'h00, 7'h00, 1'b0, 4'd10}, // R10
    '{1'b1, 1'b0, 8'hF4, 32'h00000000, 7'h00, 7'h00, 1'b0, 4'd10}, // R10 sent cleared
    '{1'b0, 1'b1, 8'hF4, 32'h00840000, 7'h00, 7'h00, 1'b0, 4'd9},  // R9 no flag yet
    '{1'b1, 1'b0, 8'hF4, 32'h00840000, 7'h00, 7'h00, 1'b0, 4'd5},  // R5
    '{1'b0, 1'b0, 8'h00, 32'h00000000, 7'h04, 7'h00, 1'b1, 4'd7},  // R7 done ch2
    '{1'b1, 1'b0, 8'hF4, 32'h84840000, 7'h00, 7'h00, 1'b0, 4'd7},  // R7
    '{1'b1, 1'b0, 8'hA8, 32'h00000000, 7'h00, 7'h00, 1'b0, 4'd8},  // R8
    '{1'b0, 1'b0, 8'h00, 32'h00000000, 7'h08, 7'h00, 1'b0, 4'd7},  // R7 ch3 not enabled
    '{1'b1, 1'b0, 8'hF4, 32'h84840000, 7'h00, 7'h00, 1'b0, 4'd7},  // R7
    '{1'b0, 1'b1, 8'hF4, 32'h00840000, 7'h00, 7'h00, 1'b0, 4'd6},  // R6 zero keeps
    '{1'b1, 1'b0, 8'hF4, 32'h84840000, 7'h00, 7'h00, 1'b0, 4'd6},  // R6
    '{1'b0, 1'b1, 8'hF4, 32'h04840000, 7'h04, 7'h00, 1'b0, 4'd11}, // R11 set beats clear
    '{1'b1, 1'b0, 8'hF4, 32'h84840000, 7'h00, 7'h00, 1'b0, 4'd11}, // R11
    '{1'b0, 1'b1, 8'hF4, 32'h04840000, 7'h00, 7'h00, 1'b0, 4'd6},  // R6 clear
    '{1'b1, 1'b0, 8'hF4, 32'h00840000, 7'h00, 7'h00, 1'b0, 4'd10}, // R10
    '{1'b0, 1'b1, 8'hA8, 32'h01000005, 7'h04, 7'h04, 1'b1, 4'd11}, // R11 write beats done
    '{1'b1, 1'b0, 8'hA8, 32'h01000005, 7'h00, 7'h00, 1'b0, 4'd11}, // R11
    '{1'b1, 1'b0, 8'hF4, 32'h84840000, 7'h00, 7'h00, 1'b0, 4'd9},  // R9
    '{1'b0, 1'b1, 8'hF4, 32'h00040000, 7'h00, 7'h00, 1'b0, 4'd9},  // R9 global off
    '{1'b1, 1'b0, 8'hF4, 32'h04040000, 7'h00, 7'h00, 1'b0, 4'd9},  // R9
    '{1'b0, 1'b1, 8'hF4, 32'h00840000, 7'h00, 7'h00, 1'b1, 4'd10}, // R10 re-raise
    '{1'b1, 1'b0, 8'hF4, 32'h84840000, 7'h00, 7'h00, 1'b0, 4'd10}  // R10
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [6:0]  done_i = '0;
  logic [6:0]  start_o;
  logic        irq_o;
  int          checks = 0;
  int          errors = 0;

  always #10 clk_i = ~clk_i;

  dma_regfile u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .done_i  (done_i),
    .start_o (start_o),
    .irq_o   (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 start", {25'd0, start_o}, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      we_i    = VECS[i].wr;
      addr_i  = VECS[i].addr;
      wdata_i = VECS[i].wr ? VECS[i].data : 32'd0;
      done_i  = VECS[i].done;
      #1;
      if (VECS[i].rd) chk($sformatf("R%0d v%0d rdata", VECS[i].req, i), rdata_o, VECS[i].data);
      @(negedge clk_i);
      we_i   = 1'b0;
      done_i = '0;
      chk($sformatf("R%0d v%0d start", VECS[i].req, i), {25'd0, start_o}, {25'd0, VECS[i].st});
      chk($sformatf("R%0d v%0d irq", VECS[i].req, i), {31'd0, irq_o}, {31'd0, VECS[i].irq});
    end
    // R1: reset mid-run restores defaults
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_chk("R1 pcr", 8'hF0, 32'h07654321);
    rd_chk("R1 icr", 8'hF4, 32'h00000000);
    rd_chk("R1 ch6 addr", 8'hE0, 32'h00000000);
    rd_chk("R1 ch2 ctrl", 8'hA8, 32'h00000000);
    chk("R1 start after reset", {25'd0, start_o}, 32'd0);
    // R3: reset enables gate a start on channel 2
    addr_i = 8'hA8; wdata_i = 32'h01000000; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    chk("R3 start after reset", {25'd0, start_o}, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule